// File: doc/BRIEF.md
# DRAM Strobe Decoder and Refresh Sequencer

This block is the control logic inside a DRAM device that uses multiplexed addresses. It samples the active-low row strobe, column strobe, write-enable and output-enable pins on a fast internal clock. From the order in which these pins change it decides what kind of cycle the memory controller has started.

A row strobe that falls while the column strobe is high opens a row. That row's address comes from the address pins. If a column strobe then follows, the cycle is a read or write access; if none follows, it is a refresh of that row only. A row strobe that falls while the column strobe is already low starts an internal refresh. The row for an internal refresh comes from a 10-bit counter, and the address pins are ignored. When the output was still holding read data at that moment, the refresh is a hidden one.

If both strobes stay low long enough, the block moves into self-refresh. In self-refresh, a tick counter issues refreshes on its own until both strobes return high. The write-enable level at the start of an internal refresh sets or clears a test-mode flag. The block also produces the enable for the data output drivers.

Each refreshed row is reported on `rowAddr` together with a one-cycle `refreshStrobe`. The storage array consumes these.

Top module: `drs_top`

## Requirements
- R1: After reset, `rowAddr` is 0, `refreshStrobe`, `selfRefresh`, `testMode` and `dqDriveEn` are 0, `cycleKind` is 0 (idle), and the internal row counter is 0.
- R2: A row-strobe fall with `casN` high produces exactly one `refreshStrobe` pulse on the next clock. `rowAddr` then equals the `addr` sampled at that fall, and `cycleKind` becomes 1 (row open). The internal counter is not changed.
- R3: If the row strobe rises again without any column-strobe fall, `cycleKind` becomes 3 (row-only refresh), and `dqDriveEn` stays 0 throughout the cycle.
- R4: A column-strobe fall while a row is open sets `cycleKind` to 2 (access). With `weN` high at that fall (read) and `oeN` low, `dqDriveEn` is 1 on the next clock. With `weN` low at that fall (early write), `dqDriveEn` stays 0 for the whole cycle, even with `oeN` low.
- R5: `dqDriveEn` is 0 on the clock after `casN` or `oeN` is seen high.
- R6: A row-strobe fall with `casN` already low is an internal refresh: `cycleKind` becomes 4, the `addr` pins are ignored, `rowAddr` is the counter value, and the counter advances by one. Repeating the row-strobe fall while `casN` stays low refreshes successive rows.
- R7: The row counter wraps from 1023 to 0.
- R8: An internal refresh that starts while `dqDriveEn` is 1 is a hidden refresh. `cycleKind` becomes 5, the row comes from the counter, and `dqDriveEn` stays 1.
- R9: An internal refresh started with `weN` low sets `testMode`. One started with `weN` high clears it, and so does a row-only refresh (R3). A read or write access leaves it unchanged.
- R10: `selfRefresh` becomes 1, with `cycleKind` 6, exactly `SELF_ENTRY_CYCLES` clocks after the internal-refresh row-strobe fall, provided both strobes stay low throughout.
- R11: In self-refresh, a `refreshStrobe` carrying the next counter row is issued every `TICK_CYCLES` clocks, the first one `TICK_CYCLES` clocks after entry.
- R12: Self-refresh is left on the clock after both strobes are seen high, and `cycleKind` returns to 0. A column strobe going high by itself does not end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ROW_BITS | Multiplexed address pins |
| rowAddr | output | ROW_BITS | Row being refreshed or opened |
| refreshStrobe | output | 1 | One-cycle pulse per refreshed row |
| cycleKind | output | 3 | 0 idle, 1 row open, 2 access, 3 row-only refresh, 4 internal refresh, 5 hidden refresh, 6 self-refresh |
| selfRefresh | output | 1 | Self-refresh active |
| testMode | output | 1 | Test mode active |
| dqDriveEn | output | 1 | Data output driver enable |

## Verification
The bench checks where each refreshed row comes from. A design that used the address pins during an internal refresh, or that let a normal access bump the counter, would put the wrong rows into the scoreboard queue. The counter is driven all the way through 1023 so that a missing wrap shows up as a row mismatch. The bench also measures the self-refresh entry and the tick spacing to the exact clock, and raises the column strobe by itself to catch a design that leaves self-refresh too early. Finally it checks that an early write never drives the data outputs and that a hidden refresh keeps them driven. Test mode is cleared by both of its exit routes.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE    = 3'd0,
    KIND_ROWOPEN = 3'd1,
    KIND_ACCESS  = 3'd2,
    KIND_RASONLY = 3'd3,
    KIND_CBR     = 3'd4,
    KIND_HIDDEN  = 3'd5,
    KIND_SELF    = 3'd6
  } cycleKind_e;

  // Strobes from control to datapath: which row source refreshes this clock.
  typedef struct packed {
    logic loadExt;
    logic useCounter;
  } rowStrobe_t;

endpackage

// File: rtl/drs_ctrl.sv
module drs_ctrl
  import drs_pkg::*;
#(
  parameter int SELF_ENTRY_CYCLES = 5000,
  parameter int TICK_CYCLES       = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       oeN,
  output rowStrobe_t strb,
  output cycleKind_e kind,
  output logic       selfRefresh,
  output logic       testMode,
  output logic       dqDriveEn
);

  localparam int LOW_W  = $clog2(SELF_ENTRY_CYCLES + 1);
  localparam int TICK_W = $clog2(TICK_CYCLES + 1);
  localparam logic [LOW_W-1:0]  LOW_LAST  = LOW_W'(SELF_ENTRY_CYCLES - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_CYCLES - 1);

  logic rasD, casD;
  logic isRead;
  logic [LOW_W-1:0]  lowCnt;
  logic [TICK_W-1:0] tickCnt;

  logic rasFall, rasRise, casFall;
  logic rowActive, colStrobe, readNow;
  logic selfExit, lowWindow, enterSelf, tickFire;
  logic internalStart, dqNext;

  always_comb begin
    rasFall   = rasD & ~rasN;
    rasRise   = ~rasD & rasN;
    casFall   = casD & ~casN;
    rowActive = (kind == KIND_ROWOPEN) || (kind == KIND_ACCESS);
    colStrobe = casFall & ~rasN & ~rasFall & rowActive;
    readNow   = colStrobe ? weN : ((kind == KIND_ACCESS) & isRead);
    selfExit  = selfRefresh & rasN & casN;
    lowWindow = ((kind == KIND_CBR) || (kind == KIND_HIDDEN)) &
                ~rasN & ~casN & ~rasFall & ~selfRefresh;
    enterSelf = lowWindow & (lowCnt == LOW_LAST);
    tickFire  = selfRefresh & ~selfExit & (tickCnt == TICK_LAST);
    internalStart = rasFall & ~casN & ~selfRefresh;
    dqNext    = ~casN & ~oeN & ((~rasN & readNow) | dqDriveEn);
    strb.loadExt    = rasFall & casN & ~selfRefresh;
    strb.useCounter = internalStart | tickFire;
  end

  // Strobe history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasD <= 1'b1;
      casD <= 1'b1;
    end else begin
      rasD <= rasN;
      casD <= casN;
    end
  end

  // Cycle classification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kind <= KIND_IDLE;
    end else if (selfExit) begin
      kind <= KIND_IDLE;
    end else if (enterSelf) begin
      kind <= KIND_SELF;
    end else if (rasFall && !selfRefresh) begin
      if (casN)          kind <= KIND_ROWOPEN;
      else if (dqDriveEn) kind <= KIND_HIDDEN;
      else               kind <= KIND_CBR;
    end else if (colStrobe) begin
      kind <= KIND_ACCESS;
    end else if (rasRise && kind == KIND_ROWOPEN) begin
      kind <= KIND_RASONLY;
    end
  end

  // Read/write latch per column strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          isRead <= 1'b0;
    else if (colStrobe) isRead <= weN;
  end

  // Test mode flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      testMode <= 1'b0;
    else if (internalStart)
      testMode <= ~weN;
    else if (rasRise && kind == KIND_ROWOPEN)
      testMode <= 1'b0;
  end

  // Output driver enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dqDriveEn <= 1'b0;
    else       dqDriveEn <= dqNext;
  end

  // Self-refresh entry timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     lowCnt <= '0;
    else if (lowWindow && !enterSelf) lowCnt <= lowCnt + 1'b1;
    else                           lowCnt <= '0;
  end

  // Self-refresh state and oscillator tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selfRefresh <= 1'b0;
      tickCnt     <= '0;
    end else begin
      if (selfExit)       selfRefresh <= 1'b0;
      else if (enterSelf) selfRefresh <= 1'b1;
      if (selfRefresh && !selfExit)
        tickCnt <= tickFire ? '0 : tickCnt + 1'b1;
      else
        tickCnt <= '0;
    end
  end

  // R5: driver released after column strobe or output enable goes high
  p_dq_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (casN || oeN) |=> !dqDriveEn);

  // R12: both strobes high ends self-refresh
  p_self_exit_r12: assert property (@(posedge clk) disable iff (!rstN)
    (selfRefresh && rasN && casN) |=> (!selfRefresh && kind == KIND_IDLE));

  // R9: test mode only rises from an internal refresh start with write enable low
  p_test_entry_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testMode) |-> ($past(!weN) && $past(!casN)));

  // R3: row-only refresh never drives the outputs
  p_rasonly_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_ROWOPEN) |-> !dqDriveEn);

  // R10: self-refresh only entered while both strobes are low
  p_self_entry_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfRefresh) |-> ($past(!rasN) && $past(!casN)));

endmodule

// File: rtl/drs_dpath.sv
module drs_dpath
  import drs_pkg::*;
#(
  parameter int ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ROW_BITS-1:0] addr,
  input  rowStrobe_t          strb,
  output logic [ROW_BITS-1:0] rowAddr,
  output logic                refreshStrobe
);

  localparam logic [ROW_BITS-1:0] ROW_LAST = {ROW_BITS{1'b1}};

  logic [ROW_BITS-1:0] rowCnt;
  logic [ROW_BITS-1:0] rowCntNext;

  always_comb begin
    rowCntNext = (rowCnt == ROW_LAST) ? '0 : rowCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCnt        <= '0;
      rowAddr       <= '0;
      refreshStrobe <= 1'b0;
    end else begin
      refreshStrobe <= strb.loadExt | strb.useCounter;
      if (strb.useCounter) begin
        rowAddr <= rowCnt;
        rowCnt  <= rowCntNext;
      end else if (strb.loadExt) begin
        rowAddr <= addr;
      end
    end
  end

  // R6: one row source per clock
  p_one_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadExt, strb.useCounter}));

  // R2: external row refresh leaves the counter alone and reports the pins
  p_ext_row_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadExt |=> (refreshStrobe && $stable(rowCnt) && rowAddr == $past(addr)));

  // R7: counter wraps to zero after the last row
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.useCounter && rowCnt == ROW_LAST) |=> (rowCnt == '0 && rowAddr == ROW_LAST));

endmodule

// File: rtl/drs_top.sv
module drs_top
  import drs_pkg::*;
#(
  parameter int ROW_BITS          = 10,
  parameter int SELF_ENTRY_CYCLES = 5000,
  parameter int TICK_CYCLES       = 800
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic                oeN,
  input  logic [ROW_BITS-1:0] addr,
  output logic [ROW_BITS-1:0] rowAddr,
  output logic                refreshStrobe,
  output logic [2:0]          cycleKind,
  output logic                selfRefresh,
  output logic                testMode,
  output logic                dqDriveEn
);

  rowStrobe_t strb;
  cycleKind_e kind;

  drs_ctrl #(
    .SELF_ENTRY_CYCLES(SELF_ENTRY_CYCLES),
    .TICK_CYCLES      (TICK_CYCLES)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .oeN        (oeN),
    .strb       (strb),
    .kind       (kind),
    .selfRefresh(selfRefresh),
    .testMode   (testMode),
    .dqDriveEn  (dqDriveEn)
  );

  drs_dpath #(
    .ROW_BITS(ROW_BITS)
  ) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .addr         (addr),
    .strb         (strb),
    .rowAddr      (rowAddr),
    .refreshStrobe(refreshStrobe)
  );

  assign cycleKind = kind;

endmodule

// File: tb/tb_drs_top.sv
`timescale 1ns/1ps
module tb_drs_top;

  localparam int ROW_BITS = 10;
  localparam int ENTRY    = 5000;
  localparam int TICK     = 800;

  logic clk = 1'b0;
  logic rstN, rasN, casN, weN, oeN;
  logic [ROW_BITS-1:0] addr;
  logic [ROW_BITS-1:0] rowAddr;
  logic refreshStrobe, selfRefresh, testMode, dqDriveEn;
  logic [2:0] cycleKind;

  int checks = 0;
  int fails  = 0;
  int expCnt = 0;
  int expQ[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  drs_top #(.ROW_BITS(ROW_BITS), .SELF_ENTRY_CYCLES(ENTRY), .TICK_CYCLES(TICK)) dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .rowAddr(rowAddr), .refreshStrobe(refreshStrobe),
    .cycleKind(cycleKind), .selfRefresh(selfRefresh), .testMode(testMode),
    .dqDriveEn(dqDriveEn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushCounterRow();
    expQ.push_back(expCnt);
    expCnt = (expCnt + 1) % 1024;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Scoreboard monitor: every refresh pulse must match the next expected row
  always @(negedge clk) begin
    if (rstN === 1'b1 && refreshStrobe === 1'b1) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2/R6 unexpected refresh row", int'(rowAddr), -1);
      end else begin
        automatic int e = expQ.pop_front();
        chk(rowAddr == e, "R2 R6 R7 R11 refresh row", int'(rowAddr), e);
      end
    end
  end

  // Internal refresh (CBR): column strobe first, then row strobe
  task automatic cbr(input bit we);
    weN = we; casN = 1'b0; step();
    addr = 10'h2C7; rasN = 1'b0; pushCounterRow(); step();
    chk(cycleKind == 3'd4, "R6 internal refresh kind", cycleKind, 4);
    rasN = 1'b1; step();
    casN = 1'b1; weN = 1'b1; step();
  endtask

  task automatic rasOnly(input int row);
    addr = row[ROW_BITS-1:0]; rasN = 1'b0; expQ.push_back(row); step();
    chk(cycleKind == 3'd1, "R2 row open kind", cycleKind, 1);
    step();
    rasN = 1'b1; step();
    chk(cycleKind == 3'd3, "R3 row-only kind", cycleKind, 3);
    chk(dqDriveEn == 1'b0, "R3 outputs quiet", dqDriveEn, 0);
  endtask

  task automatic readAccess(input int row);
    addr = row[ROW_BITS-1:0]; rasN = 1'b0; expQ.push_back(row); step();
    addr = 10'h011; weN = 1'b1; oeN = 1'b0; casN = 1'b0; step();
    chk(cycleKind == 3'd2, "R4 access kind", cycleKind, 2);
    chk(dqDriveEn == 1'b1, "R4 read drives", dqDriveEn, 1);
  endtask

  initial begin
    rstN = 1'b0; rasN = 1'b1; casN = 1'b1; weN = 1'b1; oeN = 1'b1; addr = '0;
    step(3);
    rstN = 1'b1; step();
    // R1 reset state
    chk(rowAddr == 0, "R1 rowAddr", rowAddr, 0);
    chk(cycleKind == 0, "R1 kind", cycleKind, 0);
    chk({selfRefresh, testMode, dqDriveEn, refreshStrobe} == 4'b0, "R1 flags",
        {selfRefresh, testMode, dqDriveEn, refreshStrobe}, 0);

    // R2 R3 row-only refresh
    rasOnly(10'h155);

    // R4 R5 read access with output enable toggles
    readAccess(10'h2A0);
    oeN = 1'b1; step();
    chk(dqDriveEn == 1'b0, "R5 OE high releases", dqDriveEn, 0);
    oeN = 1'b0; step();
    chk(dqDriveEn == 1'b1, "R4 OE low re-drives", dqDriveEn, 1);
    casN = 1'b1; step();
    chk(dqDriveEn == 1'b0, "R5 CAS high releases", dqDriveEn, 0);
    rasN = 1'b1; oeN = 1'b1; step();

    // R4 early write never drives
    addr = 10'h033; rasN = 1'b0; expQ.push_back(10'h033); step();
    weN = 1'b0; oeN = 1'b0; casN = 1'b0; step();
    chk(dqDriveEn == 1'b0, "R4 early write quiet", dqDriveEn, 0);
    step();
    chk(dqDriveEn == 1'b0, "R4 early write quiet later", dqDriveEn, 0);
    casN = 1'b1; rasN = 1'b1; weN = 1'b1; oeN = 1'b1; step();

    // R6 counter untouched by accesses: first internal refresh hits row 0
    cbr(1'b1);
    // R6 successive refreshes with column strobe held low
    casN = 1'b0; step();
    rasN = 1'b0; pushCounterRow(); step();
    rasN = 1'b1; step();
    rasN = 1'b0; pushCounterRow(); step();
    chk(cycleKind == 3'd4, "R6 successive kind", cycleKind, 4);
    rasN = 1'b1; step();
    casN = 1'b1; step();

    // R9 test mode entry and exits
    cbr(1'b0);
    chk(testMode == 1'b1, "R9 test entry", testMode, 1);
    readAccess(10'h0F0);
    casN = 1'b1; oeN = 1'b1; step();
    rasN = 1'b1; step();
    chk(testMode == 1'b1, "R9 access keeps test", testMode, 1);
    cbr(1'b1);
    chk(testMode == 1'b0, "R9 exit by internal refresh", testMode, 0);
    cbr(1'b0);
    chk(testMode == 1'b1, "R9 re-entry", testMode, 1);
    rasOnly(10'h3C3);
    chk(testMode == 1'b0, "R9 exit by row-only", testMode, 0);

    // R8 hidden refresh
    readAccess(10'h077);
    rasN = 1'b1; step();
    chk(dqDriveEn == 1'b1, "R8 data held after RAS high", dqDriveEn, 1);
    rasN = 1'b0; pushCounterRow(); step();
    chk(cycleKind == 3'd5, "R8 hidden kind", cycleKind, 5);
    chk(dqDriveEn == 1'b1, "R8 data still valid", dqDriveEn, 1);
    rasN = 1'b1; step();
    casN = 1'b1; step();
    chk(dqDriveEn == 1'b0, "R5 release after hidden", dqDriveEn, 0);
    oeN = 1'b1; step();

    // R7 run the counter up to the wrap
    while (expCnt != 1023) cbr(1'b1);
    cbr(1'b1);
    chk(rowAddr == 1023, "R7 last row", rowAddr, 1023);
    cbr(1'b1);
    chk(rowAddr == 0, "R7 wrapped row", rowAddr, 0);

    // R10 R11 R12 self-refresh
    casN = 1'b0; step();
    rasN = 1'b0; pushCounterRow(); step(ENTRY);
    chk(selfRefresh == 1'b0, "R10 not yet in self", selfRefresh, 0);
    step();
    chk(selfRefresh == 1'b1, "R10 self entered", selfRefresh, 1);
    chk(cycleKind == 3'd6, "R10 self kind", cycleKind, 6);
    pushCounterRow(); pushCounterRow();
    step(TICK - 1);
    chk(refreshStrobe == 1'b0, "R11 no tick early", refreshStrobe, 0);
    step();
    chk(refreshStrobe == 1'b1, "R11 first tick", refreshStrobe, 1);
    step(TICK + 4);
    #1;
    chk(expQ.size() == 0, "R11 two ticks seen", expQ.size(), 0);
    casN = 1'b1; step(2);
    chk(selfRefresh == 1'b1, "R12 CAS alone keeps self", selfRefresh, 1);
    rasN = 1'b1; step(2);
    chk(selfRefresh == 1'b0, "R12 self exit", selfRefresh, 0);
    chk(cycleKind == 3'd0, "R12 kind idle", cycleKind, 0);

    step(4);
    #1;
    chk(expQ.size() == 0, "R11 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

endmodule